// File: doc/BRIEF.md
# Deferred-invalidate cache front end with barrier drain

This block is the receive side of the coherence logic for one small direct-mapped data cache. Two kinds of message arrive from the interconnect. Invalidate probes are not applied to the cache right away. They are written into a first-in first-out probe queue and acknowledged as soon as they are queued. Read-reply fills skip that queue and write the cache line directly, so a fill can land while older invalidates are still waiting. The core issues loads against the cache. A load can hit a line whose invalidate is still queued, and it then returns the old value.

When no barrier is pending, the queue is serviced in the background, one entry at a time. After each service, and whenever the queue turns non-empty, the block waits `DRAIN_GAP` idle cycles before the next service. This throttle makes the window for stale reads as wide as a test needs.

A barrier request from the core moves a small state machine through three states. `BAR_IDLE` waits for a request. `BAR_DRAIN` services one entry every cycle and refuses new invalidates. `BAR_DONE` raises the barrier ready signal. The transitions are:
- IDLE→DRAIN when a request is seen.
- DRAIN→DONE on the clock edge where the queue is observed empty.
- DONE→IDLE when the handshake completes.

Servicing an invalidate clears the line only when the tag matches. An invalidate whose tag does not match is retired with no effect.

Top module: `inval_queue_ctrl`

## Requirements
- R1: A message with `msg_kind`=0 (invalidate) that is accepted (`msg_valid` and `msg_ready` high) is queued. `occupancy` rises by one at that clock edge. `ack_valid` is high in the next cycle, carrying the message's tag and index.
- R2: A message with `msg_kind`=1 (fill) always sees `msg_ready` high. Its tag and data are written to the line at its index on the same edge, even while invalidates for that line are queued.
- R3: When `occupancy` equals `DEPTH`, `msg_ready` is low for invalidates and `occupancy` does not grow. Fills are still accepted.
- R4: A load returns its result one cycle later: `ld_resp_valid` is high, and `ld_hit` is high exactly when the line is valid and its tag equals the load tag. A line whose invalidate is still queued still hits with its old data.
- R5: With no barrier pending, queued entries are serviced one at a time in arrival order. The first service happens `DRAIN_GAP`+1 edges after the queue becomes non-empty, and each later one happens `DRAIN_GAP`+1 edges after the previous service.
- R6: Servicing an invalidate clears the line's valid bit if the line holds the same tag. If the tag differs, the line is left unchanged.
- R7: A barrier request taken in `BAR_IDLE` with N queued entries raises `bar_ready` exactly N+2 edges later, with `occupancy` at 0. The request is held until `bar_ready` is high, and the handshake edge returns the machine to `BAR_IDLE`.
- R8: While the barrier machine is not in `BAR_IDLE`, `msg_ready` is low for invalidates.
- R9: If a fill and an invalidate service hit the same index on the same edge, the invalidate is applied after the fill. A matching tag therefore leaves the line invalid.
- R10: After reset, `occupancy`, `ack_valid`, `ld_resp_valid` and `bar_ready` are 0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Incoming message valid |
| msg_kind | input | 1 | 0 = invalidate, 1 = fill |
| msg_tag | input | TAG_W | Line tag of the message |
| msg_idx | input | IDX_W | Cache index of the message |
| msg_data | input | DATA_W | Fill data (ignored for invalidates) |
| msg_ready | output | 1 | Message can be accepted |
| ack_valid | output | 1 | Invalidate acknowledge pulse |
| ack_tag | output | TAG_W | Tag of the acknowledged invalidate |
| ack_idx | output | IDX_W | Index of the acknowledged invalidate |
| ld_valid | input | 1 | Core load request |
| ld_tag | input | TAG_W | Load tag |
| ld_idx | input | IDX_W | Load index |
| ld_resp_valid | output | 1 | Load result valid |
| ld_hit | output | 1 | Load hit |
| ld_data | output | DATA_W | Load data |
| bar_valid | input | 1 | Barrier request |
| bar_ready | output | 1 | Barrier complete |
| occupancy | output | $clog2(DEPTH+1) | Number of queued invalidates |

## Verification
Two events can coincide on one edge: a fill and the servicing of a queued invalidate aimed at the same line. The bench provokes this during a barrier drain. It queues a single invalidate and requests a barrier, then presents a fill with the same tag and index in the exact cycle the drain services that entry. A following load must miss. A miss shows that the older invalidate was ordered after the fill, and a hit would reveal the reverse ordering. A companion case uses a non-matching tag, where the same collision must leave the filled line intact.

// File: rtl/pq_pkg.sv
package pq_pkg;
    typedef enum logic {
        MSG_INVAL = 1'b0,
        MSG_FILL  = 1'b1
    } msg_kind_e;

    typedef enum logic [1:0] {
        BAR_IDLE  = 2'd0,
        BAR_DRAIN = 2'd1,
        BAR_DONE  = 2'd2
    } bar_state_e;
endpackage

// File: rtl/pq_fifo.sv
module pq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     pop_data,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/pq_cache.sv
module pq_cache #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8,
    localparam int SETS  = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic [TAG_W-1:0]  inv_tag,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_resp,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data
);
    logic [SETS-1:0]   valid;
    logic [TAG_W-1:0]  tags [SETS];
    logic [DATA_W-1:0] data [SETS];

    logic             same_line;
    logic             eff_valid;
    logic [TAG_W-1:0] eff_tag;
    logic             inv_match;

    always_comb begin
        same_line = fill_en && (fill_idx == inv_idx);
        eff_valid = same_line ? 1'b1 : valid[inv_idx];
        eff_tag   = same_line ? fill_tag : tags[inv_idx];
        inv_match = inv_en && eff_valid && (eff_tag == inv_tag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
        end else begin
            if (fill_en) begin
                valid[fill_idx] <= 1'b1;
                tags[fill_idx]  <= fill_tag;
                data[fill_idx]  <= fill_data;
            end
            if (inv_match) valid[inv_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_resp <= 1'b0;
            rd_hit  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_resp <= rd_en;
            rd_hit  <= rd_en && valid[rd_idx] && (tags[rd_idx] == rd_tag);
            rd_data <= rd_en ? data[rd_idx] : '0;
        end
    end
endmodule

// File: rtl/pq_barrier_fsm.sv
module pq_barrier_fsm
    import pq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bar_valid,
    input  logic q_empty,
    output logic drain_mode,
    output logic bar_ready,
    output logic idle
);
    bar_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= BAR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            BAR_IDLE:  if (bar_valid) state_nx = BAR_DRAIN;
            BAR_DRAIN: if (q_empty)   state_nx = BAR_DONE;
            BAR_DONE:  if (bar_valid) state_nx = BAR_IDLE;
            default:                  state_nx = BAR_IDLE;
        endcase
    end

    always_comb begin
        drain_mode = 1'b0;
        bar_ready  = 1'b0;
        idle       = 1'b0;
        unique case (state)
            BAR_IDLE:  idle       = 1'b1;
            BAR_DRAIN: drain_mode = 1'b1;
            BAR_DONE:  bar_ready  = 1'b1;
            default:   idle       = 1'b1;
        endcase
    end
endmodule

// File: rtl/inval_queue_ctrl.sv
module inval_queue_ctrl
    import pq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int IDX_W     = 3,
    parameter int TAG_W     = 4,
    parameter int DATA_W    = 8,
    parameter int DRAIN_GAP = 0,
    localparam int OCC_W    = $clog2(DEPTH + 1),
    localparam int GAP_W    = $clog2(DRAIN_GAP + 2),
    localparam int ENT_W    = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic              msg_kind,
    input  logic [TAG_W-1:0]  msg_tag,
    input  logic [IDX_W-1:0]  msg_idx,
    input  logic [DATA_W-1:0] msg_data,
    output logic              msg_ready,
    output logic              ack_valid,
    output logic [TAG_W-1:0]  ack_tag,
    output logic [IDX_W-1:0]  ack_idx,
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [IDX_W-1:0]  ld_idx,
    output logic              ld_resp_valid,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    input  logic              bar_valid,
    output logic              bar_ready,
    output logic [OCC_W-1:0]  occupancy
);
    logic             q_full, q_empty, drain_mode, bar_idle;
    logic             push_inv, fill_en, svc;
    logic [ENT_W-1:0] head;
    logic [GAP_W-1:0] gap_cnt;

    assign msg_ready = (msg_kind == MSG_FILL) ? 1'b1 : (!q_full && bar_idle);
    assign push_inv  = msg_valid && (msg_kind == MSG_INVAL) && !q_full && bar_idle;
    assign fill_en   = msg_valid && (msg_kind == MSG_FILL);
    assign svc       = !q_empty && (drain_mode || (gap_cnt == '0));

    pq_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push_inv), .push_data({msg_tag, msg_idx}),
        .pop(svc), .pop_data(head),
        .count(occupancy), .full(q_full), .empty(q_empty)
    );

    pq_cache #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_idx(msg_idx), .fill_tag(msg_tag), .fill_data(msg_data),
        .inv_en(svc), .inv_idx(head[IDX_W-1:0]), .inv_tag(head[ENT_W-1:IDX_W]),
        .rd_en(ld_valid), .rd_idx(ld_idx), .rd_tag(ld_tag),
        .rd_resp(ld_resp_valid), .rd_hit(ld_hit), .rd_data(ld_data)
    );

    pq_barrier_fsm u_bar (
        .clk(clk), .rst_n(rst_n), .bar_valid(bar_valid), .q_empty(q_empty),
        .drain_mode(drain_mode), .bar_ready(bar_ready), .idle(bar_idle)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= GAP_W'(DRAIN_GAP);
        end else if (q_empty || svc) begin
            gap_cnt <= GAP_W'(DRAIN_GAP);
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_tag   <= '0;
            ack_idx   <= '0;
        end else begin
            ack_valid <= push_inv;
            if (push_inv) begin
                ack_tag <= msg_tag;
                ack_idx <= msg_idx;
            end
        end
    end
endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msg_valid,
    input logic             msg_kind,
    input logic [IDX_W-1:0] msg_idx,
    input logic             msg_ready,
    input logic             ack_valid,
    input logic [IDX_W-1:0] ack_idx,
    input logic             ld_valid,
    input logic             ld_resp_valid,
    input logic             bar_ready,
    input logic [OCC_W-1:0] occupancy
);
    assert_ack_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_kind && msg_ready) |=> (ack_valid && ack_idx == $past(msg_idx)));

    assert_fill_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind) |-> msg_ready);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == OCC_W'(DEPTH)) |=> (occupancy <= OCC_W'(DEPTH)));

    assert_refuse_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_kind && !msg_ready) |=> (occupancy <= $past(occupancy)));

    assert_load_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> ld_resp_valid);

    assert_bar_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bar_ready |-> (occupancy == '0));
endmodule

bind inval_queue_ctrl pq_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pq_checker (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_idx(msg_idx), .msg_ready(msg_ready), .ack_valid(ack_valid), .ack_idx(ack_idx),
    .ld_valid(ld_valid), .ld_resp_valid(ld_resp_valid), .bar_ready(bar_ready),
    .occupancy(occupancy)
);

// File: tb/tb_inval_queue_ctrl.sv
module tb_inval_queue_ctrl;
    localparam int DEPTH = 8;
    localparam int GAP   = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       msg_valid = 1'b0, msg_kind = 1'b0;
    logic [3:0] msg_tag = '0;
    logic [2:0] msg_idx = '0;
    logic [7:0] msg_data = '0;
    logic       msg_ready, ack_valid;
    logic [3:0] ack_tag;
    logic [2:0] ack_idx;
    logic       ld_valid = 1'b0;
    logic [3:0] ld_tag = '0;
    logic [2:0] ld_idx = '0;
    logic       ld_resp_valid, ld_hit;
    logic [7:0] ld_data;
    logic       bar_valid = 1'b0, bar_ready;
    logic [3:0] occupancy;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    inval_queue_ctrl #(.DEPTH(DEPTH), .DRAIN_GAP(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_kind(msg_kind),
        .msg_tag(msg_tag), .msg_idx(msg_idx), .msg_data(msg_data), .msg_ready(msg_ready),
        .ack_valid(ack_valid), .ack_tag(ack_tag), .ack_idx(ack_idx),
        .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_idx(ld_idx),
        .ld_resp_valid(ld_resp_valid), .ld_hit(ld_hit), .ld_data(ld_data),
        .bar_valid(bar_valid), .bar_ready(bar_ready), .occupancy(occupancy)
    );

    // op: 0 fill, 1 invalidate, 2 load (check hit/data), 3 barrier
    localparam int NV = 15;
    localparam logic [26:0] VEC [NV] = '{
        {2'd0, 4'd1, 3'd0, 8'h11, 1'b0, 8'h00},  // R2 fill
        {2'd2, 4'd1, 3'd0, 8'h00, 1'b1, 8'h11},  // R4 hit
        {2'd1, 4'd1, 3'd0, 8'h00, 1'b0, 8'h00},  // R1 queue inval
        {2'd2, 4'd1, 3'd0, 8'h00, 1'b1, 8'h11},  // R4 stale hit
        {2'd3, 4'd0, 3'd0, 8'h00, 1'b0, 8'h00},  // R7 drain
        {2'd2, 4'd1, 3'd0, 8'h00, 1'b0, 8'h00},  // R6 removed
        {2'd0, 4'd2, 3'd1, 8'h22, 1'b0, 8'h00},
        {2'd1, 4'd7, 3'd1, 8'h00, 1'b0, 8'h00},  // R6 tag mismatch
        {2'd3, 4'd0, 3'd0, 8'h00, 1'b0, 8'h00},
        {2'd2, 4'd2, 3'd1, 8'h00, 1'b1, 8'h22},  // R6 line kept
        {2'd1, 4'd3, 3'd2, 8'h00, 1'b0, 8'h00},
        {2'd0, 4'd3, 3'd2, 8'h33, 1'b0, 8'h00},  // R2 fill bypasses queue
        {2'd2, 4'd3, 3'd2, 8'h00, 1'b1, 8'h33},
        {2'd3, 4'd0, 3'd0, 8'h00, 1'b0, 8'h00},
        {2'd2, 4'd3, 3'd2, 8'h00, 1'b0, 8'h00}   // R6 older inval removes fill
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send(input logic kind, input logic [3:0] t, input logic [2:0] i,
                        input logic [7:0] d);
        msg_valid = 1'b1; msg_kind = kind; msg_tag = t; msg_idx = i; msg_data = d;
        tick();
        msg_valid = 1'b0;
    endtask

    task automatic load(input logic [3:0] t, input logic [2:0] i,
                        output logic hit, output logic [7:0] d);
        ld_valid = 1'b1; ld_tag = t; ld_idx = i;
        tick();
        ld_valid = 1'b0;
        hit = ld_hit; d = ld_data;
        check(ld_resp_valid == 1'b1, "R4 resp", int'(ld_resp_valid), 1);
    endtask

    task automatic barrier(output int cyc);
        bar_valid = 1'b1;
        cyc = 0;
        do begin
            tick();
            cyc++;
        end while (!bar_ready && cyc < 100);
        tick();
        bar_valid = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic       h;
        logic [7:0] d;
        int         cyc;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R10 reset state
        check(occupancy == 0, "R10 occupancy", int'(occupancy), 0);
        check(ack_valid == 0, "R10 ack", int'(ack_valid), 0);
        check(bar_ready == 0, "R10 bar_ready", int'(bar_ready), 0);
        check(ld_resp_valid == 0, "R10 resp", int'(ld_resp_valid), 0);
        for (int i = 0; i < 8; i++) begin
            load(4'd0, 3'(i), h, d);
            check(h == 0, "R10 line invalid", int'(h), 0);
        end

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [1:0] op;
            logic [3:0] t;
            logic [2:0] i;
            logic [7:0] dd, ed;
            logic       eh;
            {op, t, i, dd, eh, ed} = VEC[v];
            case (op)
                2'd0: begin
                    check(msg_ready == 1 || !msg_kind, "R2", 1, 1);
                    send(1'b1, t, i, dd);
                end
                2'd1: begin
                    send(1'b0, t, i, 8'h00);
                    check(ack_valid && ack_tag == t && ack_idx == i, "R1 ack",
                          int'({ack_valid, ack_tag, ack_idx}), int'({1'b1, t, i}));
                    check(occupancy == 1, "R1 occupancy", int'(occupancy), 1);
                end
                2'd2: begin
                    load(t, i, h, d);
                    check(h == eh, "R4 hit", int'(h), int'(eh));
                    if (eh) check(d == ed, "R4 data", int'(d), int'(ed));
                end
                default: begin
                    barrier(cyc);
                    check(cyc == 3, "R7 barrier latency", cyc, 3);
                    check(occupancy == 0, "R7 empty", int'(occupancy), 0);
                end
            endcase
        end

        // R3 full queue
        for (int k = 0; k < DEPTH; k++) send(1'b0, 4'hF, 3'(k), 8'h00);
        check(occupancy == 4'(DEPTH), "R3 filled", int'(occupancy), DEPTH);
        msg_kind = 1'b0; #1;
        check(msg_ready == 0, "R3 ready low", int'(msg_ready), 0);
        msg_kind = 1'b1; #1;
        check(msg_ready == 1, "R3 fill still ready", int'(msg_ready), 1);
        send(1'b0, 4'hE, 3'd5, 8'h00);
        check(occupancy == 4'(DEPTH), "R3 no growth", int'(occupancy), DEPTH);
        check(ack_valid == 0, "R3 no ack", int'(ack_valid), 0);
        barrier(cyc);
        check(cyc == DEPTH + 2, "R7 full drain latency", cyc, DEPTH + 2);

        // R8 refuse invalidates during barrier
        send(1'b0, 4'hA, 3'd6, 8'h00);
        bar_valid = 1'b1;
        tick();
        msg_kind = 1'b0; #1;
        check(msg_ready == 0, "R8 refuse in drain", int'(msg_ready), 0);
        while (!bar_ready) tick();
        tick();
        bar_valid = 1'b0;
        check(occupancy == 0, "R8 drained", int'(occupancy), 0);

        // R9 fill and service collide on the same line, tag matches
        send(1'b0, 4'd5, 3'd4, 8'h00);
        bar_valid = 1'b1;
        tick();                           // edge into drain state
        msg_valid = 1'b1; msg_kind = 1'b1; msg_tag = 4'd5; msg_idx = 3'd4; msg_data = 8'h55;
        tick();                           // fill and service on the same edge
        msg_valid = 1'b0;
        while (!bar_ready) tick();
        tick();
        bar_valid = 1'b0;
        load(4'd5, 3'd4, h, d);
        check(h == 0, "R9 inval after fill", int'(h), 0);

        // R9 collision with a different tag keeps the fill
        send(1'b0, 4'd6, 3'd4, 8'h00);
        bar_valid = 1'b1;
        tick();
        msg_valid = 1'b1; msg_kind = 1'b1; msg_tag = 4'd5; msg_idx = 3'd4; msg_data = 8'h56;
        tick();
        msg_valid = 1'b0;
        while (!bar_ready) tick();
        tick();
        bar_valid = 1'b0;
        load(4'd5, 3'd4, h, d);
        check(h == 1 && d == 8'h56, "R9 mismatch keeps line", int'(d), 8'h56);

        // R5 throttled background drain in arrival order
        send(1'b1, 4'd8, 3'd3, 8'h83);
        send(1'b1, 4'd9, 3'd7, 8'h97);
        send(1'b0, 4'd8, 3'd3, 8'h00);    // push edge e0
        send(1'b0, 4'd9, 3'd7, 8'h00);    // e1
        repeat (20) tick();               // e21
        check(occupancy == 2, "R5 none serviced early", int'(occupancy), 2);
        repeat (27) tick();               // e48: first serviced at e41
        check(occupancy == 1, "R5 one serviced", int'(occupancy), 1);
        load(4'd8, 3'd3, h, d);           // e49
        check(h == 0, "R5 first entry applied", int'(h), 0);
        load(4'd9, 3'd7, h, d);           // e50
        check(h == 1 && d == 8'h97, "R5 second still pending", int'(h), 1);
        repeat (40) tick();               // e90: second at e82
        check(occupancy == 0, "R5 all serviced", int'(occupancy), 0);
        load(4'd9, 3'd7, h, d);
        check(h == 0, "R5 second applied", int'(h), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule